// File: doc/BRIEF.md
# Overvoltage Protection Sequencing Controller

This block decides when an external pass switch may conduct. It takes two supply-status levels from outside comparators. One is high while the supply is too low. The other is high while the supply is too high. Any hysteresis is applied before the levels reach the block. The block drives two outputs: an enable for the switch's gate drive and an active-high fault flag.

The block waits for the supply to rise out of the low region and then runs a qualification delay. When that delay ends, it looks at the overvoltage level. If the supply is in range, it turns the gate on. The fault flag stays high for a second blanking delay of the same length and is released after it. A supply that leaves the valid window at any point shuts the gate off at once, bypassing every timer.

Both delays are counted in ticks of a prescaled clock, so a tick rate and a tick count set the time. Both inputs first pass through a two-flop synchronizer.

Top module: `ovp_seq_top`

## Requirements
- R1: While the synchronous reset is high, and after it is released with the supply low, gate_en is 0 and fault_flag is 1.
- R2: While uv_in stays high, gate_en stays 0 and fault_flag stays 1, however long that lasts.
- R3: After uv_in falls, with ov_in low at the end of the delay, gate_en rises exactly 3 + CYCLES_PER_TICK*DELAY_TICKS clock edges later. The 3 edges are two synchronizer stages and the state register.
- R4: From the edge where gate_en rises, fault_flag stays 1 for CYCLES_PER_TICK*DELAY_TICKS edges and then falls, with gate_en still 1.
- R5: Once fault_flag has fallen, gate_en 1 and fault_flag 0 hold for as long as both inputs stay low.
- R6: If ov_in is high when the qualification delay ends, gate_en stays 0 and fault_flag stays 1 for as long as ov_in stays high.
- R7: In the case of R6, gate_en rises 3 edges after ov_in falls, with no new delay. The blanking period of R4 then follows.
- R8: With the gate on, ov_in or uv_in going high brings gate_en to 0 and fault_flag to 1 exactly 3 edges later, with no timer involved.
- R9: A fault during the blanking period turns the gate off within 3 edges. A later turn-on again needs the full qualification delay.
- R10: uv_in rising during the qualification delay aborts it. After uv_in falls again, the full delay of R3 is counted anew.
- R11: A pulse on ov_in that begins and ends inside the qualification delay does not change when gate_en rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_in | input | 1 | High while the supply is below the lower threshold |
| ov_in | input | 1 | High while the supply is above the upper threshold |
| gate_en | output | 1 | Enables the pass switch's gate drive |
| fault_flag | output | 1 | High while the supply is not qualified or the blanking period runs |

## Verification
The failure that matters most is a state the controller should not hold. If it believes it is on while the supply is out of range, gate_en stays high past the three-edge fault window. If it skips the blanking phase, fault_flag falls on the same edge that gate_en rises. A wrong timer shows up as gate_en or fault_flag moving one or more edges away from the count fixed by R3 and R4. A stale timer left over from an aborted qualification shows up as an early turn-on after a uv_in glitch or a startup fault. Random supply sequences are compared every cycle against a model built from the requirements, so any such divergence is caught on the cycle it first reaches the outputs.

// File: rtl/ovp_seq_pkg.sv
package ovp_seq_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_QUALIFY = 3'd1,
        ST_OV_WAIT = 3'd2,
        ST_STARTUP = 3'd3,
        ST_ON      = 3'd4
    } ovp_state_e;

    typedef struct packed {
        ovp_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/ovp_sync.sv
module ovp_sync #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] first;
        logic [WIDTH-1:0] second;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d.first  = async_in;
        r_d.second = r_q.first;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.first  <= RST_VAL;
            r_q.second <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_out = r_q.second;

endmodule

// File: rtl/ovp_delay_timer.sv
module ovp_delay_timer #(
    parameter int CYCLES_PER_TICK = 125000,
    parameter int DELAY_TICKS     = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic done
);

    localparam int TICK_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;

    logic              tick_pulse;
    logic [TICK_W-1:0] tick_d, tick_q;

    generate
        if (CYCLES_PER_TICK > 1) begin : g_prescale
            localparam int PRE_W = $clog2(CYCLES_PER_TICK);
            logic [PRE_W-1:0] pre_d, pre_q;
            logic             pre_wrap;

            always_comb begin
                pre_wrap = (pre_q == PRE_W'(CYCLES_PER_TICK - 1));
                if (!run || clr) begin
                    pre_d = '0;
                end else if (pre_wrap) begin
                    pre_d = '0;
                end else begin
                    pre_d = pre_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_d;
                end
            end

            assign tick_pulse = run && pre_wrap;
        end else begin : g_direct
            assign tick_pulse = run;
        end
    endgenerate

    always_comb begin
        if (!run || clr) begin
            tick_d = '0;
        end else if (tick_pulse) begin
            tick_d = tick_q + 1'b1;
        end else begin
            tick_d = tick_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

    assign done = tick_pulse && (tick_q == TICK_W'(DELAY_TICKS - 1));

endmodule

// File: rtl/ovp_seq_fsm.sv
module ovp_seq_fsm
    import ovp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic uv_s,
    input  logic ov_s,
    input  logic delay_done,
    output logic timer_run,
    output logic timer_clr,
    output logic gate_en,
    output logic fault_flag
);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_STANDBY: begin
                if (!uv_s) r_d.state = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (uv_s) begin
                    r_d.state = ST_STANDBY;
                end else if (delay_done) begin
                    r_d.state = ov_s ? ST_OV_WAIT : ST_STARTUP;
                end
            end
            ST_OV_WAIT: begin
                if (uv_s) begin
                    r_d.state = ST_STANDBY;
                end else if (!ov_s) begin
                    r_d.state = ST_STARTUP;
                end
            end
            ST_STARTUP: begin
                if (uv_s || ov_s) begin
                    r_d.state = ST_STANDBY;
                end else if (delay_done) begin
                    r_d.state = ST_ON;
                end
            end
            ST_ON: begin
                if (uv_s || ov_s) r_d.state = ST_STANDBY;
            end
            default: r_d.state = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_STANDBY;
        end else begin
            r_q <= r_d;
        end
    end

    assign timer_run  = (r_q.state == ST_QUALIFY) || (r_q.state == ST_STARTUP);
    assign timer_clr  = (r_d.state != r_q.state);
    assign gate_en    = (r_q.state == ST_STARTUP) || (r_q.state == ST_ON);
    assign fault_flag = (r_q.state != ST_ON);

endmodule

// File: rtl/ovp_seq_top.sv
module ovp_seq_top #(
    parameter int CYCLES_PER_TICK = 125000,
    parameter int DELAY_TICKS     = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_in,
    input  logic ov_in,
    output logic gate_en,
    output logic fault_flag
);

    logic [1:0] status_sync;
    logic       uv_sync;
    logic       ov_sync;
    logic       timer_run;
    logic       timer_clr;
    logic       delay_done;

    ovp_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({uv_in, ov_in}),
        .sync_out (status_sync)
    );

    assign uv_sync = status_sync[1];
    assign ov_sync = status_sync[0];

    ovp_delay_timer #(
        .CYCLES_PER_TICK (CYCLES_PER_TICK),
        .DELAY_TICKS     (DELAY_TICKS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (timer_run),
        .clr  (timer_clr),
        .done (delay_done)
    );

    ovp_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .uv_s       (uv_sync),
        .ov_s       (ov_sync),
        .delay_done (delay_done),
        .timer_run  (timer_run),
        .timer_clr  (timer_clr),
        .gate_en    (gate_en),
        .fault_flag (fault_flag)
    );

endmodule

// File: rtl/ovp_seq_checker.sv
module ovp_seq_checker (
    input logic clk,
    input logic rst,
    input logic uv_s,
    input logic ov_s,
    input logic gate_en,
    input logic fault_flag
);

    // R1: the edge after reset leaves the gate off and the flag raised
    a_r1_reset_safe: assert property (@(posedge clk)
        rst |=> (!gate_en && fault_flag));

    // R8: a synchronized fault removes the gate on the next edge
    a_r8_fault_cuts_gate: assert property (@(posedge clk) disable iff (rst)
        (uv_s || ov_s) |=> (!gate_en && fault_flag));

    // R5: a released flag implies the gate is on
    a_r5_flag_low_gate_on: assert property (@(posedge clk) disable iff (rst)
        !fault_flag |-> gate_en);

    // R4: the flag only falls after the gate has already been on
    a_r4_blank_first: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_flag) |-> $past(gate_en));

    // R3: the gate only turns on out of an in-window supply
    a_r3_rise_in_window: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_en) |-> $past(!uv_s && !ov_s));

    // R5: the on state holds while the supply stays in range
    a_r5_on_holds: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !fault_flag && !uv_s && !ov_s) |=> (gate_en && !fault_flag));

endmodule

bind ovp_seq_top ovp_seq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .uv_s       (uv_sync),
    .ov_s       (ov_sync),
    .gate_en    (gate_en),
    .fault_flag (fault_flag)
);

// File: tb/tb_ovp_seq_top.sv
module tb_ovp_seq_top;

    localparam int CPT = 4;
    localparam int DT  = 5;
    localparam int T   = CPT * DT;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uv_in = 1'b1;
    logic ov_in = 1'b0;
    logic gate_en;
    logic fault_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit model_cmp = 1'b0;

    // requirement model state: 0 standby, 1 qualify, 2 ov wait, 3 startup, 4 on
    int  m_st  = 0;
    int  m_cnt = 0;
    logic m_uv1 = 1'b1, m_uv2 = 1'b1, m_ov1 = 1'b0, m_ov2 = 1'b0;

    always #4 clk = ~clk;

    ovp_seq_top #(
        .CYCLES_PER_TICK (CPT),
        .DELAY_TICKS     (DT)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .uv_in      (uv_in),
        .ov_in      (ov_in),
        .gate_en    (gate_en),
        .fault_flag (fault_flag)
    );

    function automatic logic exp_gate(input int st);
        return (st == 3) || (st == 4);
    endfunction

    function automatic logic exp_flag(input int st);
        return st != 4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st <= 0; m_cnt <= 0;
            m_uv1 <= 1'b1; m_uv2 <= 1'b1; m_ov1 <= 1'b0; m_ov2 <= 1'b0;
        end else begin
            m_uv1 <= uv_in; m_uv2 <= m_uv1;
            m_ov1 <= ov_in; m_ov2 <= m_ov1;
            case (m_st)
                0: if (!m_uv2) begin m_st <= 1; m_cnt <= 0; end
                1: if (m_uv2) m_st <= 0;
                   else if (m_cnt == T - 1) begin m_st <= m_ov2 ? 2 : 3; m_cnt <= 0; end
                   else m_cnt <= m_cnt + 1;
                2: if (m_uv2) m_st <= 0;
                   else if (!m_ov2) begin m_st <= 3; m_cnt <= 0; end
                3: if (m_uv2 || m_ov2) m_st <= 0;
                   else if (m_cnt == T - 1) m_st <= 4;
                   else m_cnt <= m_cnt + 1;
                default: if (m_uv2 || m_ov2) m_st <= 0;
            endcase
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            if (model_cmp) begin
                checks++;
                if (gate_en !== exp_gate(m_st) || fault_flag !== exp_flag(m_st)) begin
                    errors++;
                    $display("FAIL R3,R4,R8 random: gate=%b flag=%b expected gate=%b flag=%b",
                             gate_en, fault_flag, exp_gate(m_st), exp_flag(m_st));
                end
            end
        end
    endtask

    task automatic chk(input string req, input logic g, input logic f);
        checks++;
        if (gate_en !== g || fault_flag !== f) begin
            errors++;
            $display("FAIL %s: gate=%b flag=%b expected gate=%b flag=%b",
                     req, gate_en, fault_flag, g, f);
        end
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(2);
        chk("R1 during reset", 1'b0, 1'b1);
        rst = 1'b0;
        step(30);
        chk("R2 low supply holds standby", 1'b0, 1'b1);

        // R3, R4, R5: clean power-up
        uv_in = 1'b0;
        step(LAT + T - 1);
        chk("R3 gate not yet on", 1'b0, 1'b1);
        step(1);
        chk("R3 gate on after delay", 1'b1, 1'b1);
        step(T - 1);
        chk("R4 flag held during blanking", 1'b1, 1'b1);
        step(1);
        chk("R4 flag released after blanking", 1'b1, 1'b0);
        step(50);
        chk("R5 on state holds", 1'b1, 1'b0);

        // R8 and R6, R7: overvoltage while on, held through a new delay
        ov_in = 1'b1;
        step(LAT - 1);
        chk("R8 not before sync latency", 1'b1, 1'b0);
        step(1);
        chk("R8 overvoltage cuts gate", 1'b0, 1'b1);
        step(T + 40);
        chk("R6 overvoltage at delay end keeps gate off", 1'b0, 1'b1);
        ov_in = 1'b0;
        step(LAT - 1);
        chk("R7 not before sync latency", 1'b0, 1'b1);
        step(1);
        chk("R7 gate on without new delay", 1'b1, 1'b1);
        step(T - 1);
        chk("R7 blanking follows", 1'b1, 1'b1);
        step(1);
        chk("R7 flag released", 1'b1, 1'b0);

        // R8: undervoltage while on
        uv_in = 1'b1;
        step(LAT);
        chk("R8 undervoltage cuts gate", 1'b0, 1'b1);
        step(5);

        // R10: glitch aborts qualification
        uv_in = 1'b0;
        step(10);
        uv_in = 1'b1;
        step(5);
        uv_in = 1'b0;
        step(LAT + T - 1);
        chk("R10 delay restarted, gate still off", 1'b0, 1'b1);
        step(1);
        chk("R10 gate on after full delay", 1'b1, 1'b1);

        // R9: fault during blanking
        step(5);
        ov_in = 1'b1;
        step(LAT);
        chk("R9 fault in blanking cuts gate", 1'b0, 1'b1);
        step(1);
        ov_in = 1'b0;
        step(T - 1);
        chk("R9 full delay again, gate off", 1'b0, 1'b1);
        step(1);
        chk("R9 gate on after full delay", 1'b1, 1'b1);

        // R11: overvoltage pulse inside qualification
        uv_in = 1'b1;
        step(6);
        uv_in = 1'b0;
        step(5);
        ov_in = 1'b1;
        step(5);
        ov_in = 1'b0;
        step(LAT + T - 1 - 10);
        chk("R11 pulse inside delay, gate not yet on", 1'b0, 1'b1);
        step(1);
        chk("R11 gate on at normal time", 1'b1, 1'b1);

        // random supply sequences against the model
        uv_in = 1'b1;
        ov_in = 1'b0;
        step(5);
        model_cmp = 1'b1;
        void'($urandom(32'h5EED_0B71));
        for (int seg = 0; seg < 400; seg++) begin
            int r;
            r = int'($urandom_range(0, 99));
            uv_in = (r < 20);
            r = int'($urandom_range(0, 99));
            ov_in = (r < 20);
            step(int'($urandom_range(1, 70)));
        end
        model_cmp = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule